// File: doc/BRIEF.md
# Byte Parity Check and Generate Unit

This unit looks after parity for one wide data port. The port word is split into byte lanes of nine bits each: eight data bits, and a parity bit at the top of the lane. Data arriving on the port bus is checked lane by lane against the parity sense chosen by a select input. An active-low error output reports a failure in any lane. This output is combinational from the bus.

On the read side the unit can replace the stored top bit of every lane with a freshly computed parity bit. This happens in two places. On the way from the FIFO memory into the read output register, the generate and parity-sense selects are sampled at the loading clock edge. On a mailbox read, the substitution is combinational and reuses the same parity trees that check the bus. While they are busy with that work, the error output is held inactive (high).

The unit never alters stored data. Words and mail contents pass in from outside storage and are changed only on the output copy.

Top module: `bytepar_port`

## Requirements
- R1: The word is split into lanes at bits [8:0], [17:9], [26:18] and [35:27], and bit 8 of each lane is its parity bit. `err_n` goes low when one or more lanes fail, and stays high when all lanes pass.
- R2: With `odd_sel`=1, a lane fails when it contains an odd number of zero bits.
- R3: With `odd_sel`=0, a lane fails when it contains an even number of zero bits.
- R4: A mailbox read with generation is selected by `cs_n`=0, `en`=1, `wr_rd`=0, `mbox_sel`=1 and `gen_en`=1. While it is selected, `err_n` is 1 whatever the value on `bus_in`.
- R5: During such a mailbox read, each lane of `mail_out` keeps the low eight bits of `mail_data`. Its top bit is set so that the whole nine-bit lane has odd parity when `odd_sel`=1 and even parity when `odd_sel`=0.
- R6: When no mailbox read with generation is selected, `mail_out` equals `mail_data` bit for bit, and `err_n` checks `bus_in` as in R1-R3.
- R7: On a rising edge with `rd_load`=1 and `gen_en`=1, `rd_word` loads `rd_data` with each lane's top bit replaced by the parity bit of R5. The parity sense is the value of `odd_sel` at that edge.
- R8: On a rising edge with `rd_load`=1 and `gen_en`=0, `rd_word` loads all 36 bits of `rd_data` unchanged.
- R9: `rd_word` is 0 after reset and keeps its value on every edge where `rd_load`=0.
- R10: `err_n` follows a change on `bus_in` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even |
| cs_n | input | 1 | Port select, active low |
| en | input | 1 | Port access enable |
| wr_rd | input | 1 | 1 for a write, 0 for a read |
| mbox_sel | input | 1 | 1 targets the mailbox, 0 the FIFO |
| gen_en | input | 1 | Parity generation enable for reads |
| bus_in | input | 36 | Incoming port bus under check |
| mail_data | input | 36 | Contents of the mail register being read |
| mail_out | output | 36 | Mail word as presented on a read |
| rd_load | input | 1 | Loads the read output register this edge |
| rd_data | input | 36 | Word fetched from FIFO memory |
| rd_word | output | 36 | FIFO read output register |
| err_n | output | 1 | Parity error, active low |

## Verification
The clocked properties assume the control inputs are steady around each rising edge, because the selects are sampled only there. The stimulus therefore changes every input on the falling edge. The read-register properties also assume `rd_data` and `odd_sel` hold their values through the loading edge. The bench never changes them between the falling edge where `rd_load` is raised and the next falling edge. The bench samples combinational outputs a short time after driving them, and samples register outputs at the falling edge that follows the loading edge.

// File: rtl/bytepar_pkg.sv
package bytepar_pkg;

   typedef enum logic {
      PAR_EVEN = 1'b0,
      PAR_ODD  = 1'b1
   } par_mode_e;

   // parity bit that makes a lane satisfy the mode, given xor of its data bits
   function automatic logic par_bit(input logic data_xor, input par_mode_e mode);
      return (mode == PAR_ODD) ? ~data_xor : data_xor;
   endfunction

   // lane failure, given xor of all lane bits including parity
   function automatic logic lane_bad(input logic lane_xor, input par_mode_e mode);
      return (mode == PAR_ODD) ? ~lane_xor : lane_xor;
   endfunction

endpackage

// File: rtl/bytepar_tree.sv
module bytepar_tree
   import bytepar_pkg::*;
#(
   parameter int LANE_W = 9
) (
   input  logic [LANE_W-1:0] lane,
   input  par_mode_e         mode,
   output logic              gen_bit,
   output logic              fail
);
   localparam int DATA_W = LANE_W - 1;

   logic data_xor;
   logic lane_xor;

   always_comb begin
      data_xor = ^lane[DATA_W-1:0];
      lane_xor = data_xor ^ lane[LANE_W-1];
      gen_bit  = par_bit(data_xor, mode);
      fail     = lane_bad(lane_xor, mode);
   end
endmodule

// File: rtl/bytepar_shared.sv
module bytepar_shared
   import bytepar_pkg::*;
#(
   parameter int BYTES  = 4,
   parameter int LANE_W = 9
) (
   input  logic [BYTES*LANE_W-1:0] bus_in,
   input  logic [BYTES*LANE_W-1:0] mail_data,
   input  logic                    mbox_gen,
   input  par_mode_e               mode,
   output logic [BYTES*LANE_W-1:0] mail_out,
   output logic                    err_n
);
   localparam int DATA_W = LANE_W - 1;

   logic [BYTES-1:0] fail_v;
   logic [BYTES-1:0] gen_v;

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      logic [LANE_W-1:0] tree_in;
      always_comb tree_in = mbox_gen ? mail_data[b*LANE_W +: LANE_W]
                                     : bus_in[b*LANE_W +: LANE_W];
      bytepar_tree #(.LANE_W(LANE_W)) u_tree (
         .lane    (tree_in),
         .mode    (mode),
         .gen_bit (gen_v[b]),
         .fail    (fail_v[b])
      );
      always_comb begin
         if (mbox_gen)
            mail_out[b*LANE_W +: LANE_W] = {gen_v[b], mail_data[b*LANE_W +: DATA_W]};
         else
            mail_out[b*LANE_W +: LANE_W] = mail_data[b*LANE_W +: LANE_W];
      end
   end

   always_comb err_n = mbox_gen | ~(|fail_v);

   // R4 mailbox generation keeps the flag inactive
   always_comb begin
      if (mbox_gen) p_flag_quiet_r4: assert (err_n == 1'b1);
   end
endmodule

// File: rtl/bytepar_outreg.sv
module bytepar_outreg
   import bytepar_pkg::*;
#(
   parameter int BYTES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic                    gen_en,
   input  par_mode_e               mode,
   input  logic [BYTES*LANE_W-1:0] rd_data,
   output logic [BYTES*LANE_W-1:0] rd_word
);
   localparam int DATA_W = LANE_W - 1;
   localparam int WORD_W = BYTES * LANE_W;

   logic [WORD_W-1:0] next_word;

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      logic gbit;
      logic unused_fail;
      bytepar_tree #(.LANE_W(LANE_W)) u_tree (
         .lane    (rd_data[b*LANE_W +: LANE_W]),
         .mode    (mode),
         .gen_bit (gbit),
         .fail    (unused_fail)
      );
      always_comb begin
         next_word[b*LANE_W +: DATA_W] = rd_data[b*LANE_W +: DATA_W];
         next_word[b*LANE_W + DATA_W]  = gen_en ? gbit : rd_data[b*LANE_W + DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rd_word <= '0;
      else if (load) rd_word <= next_word;
   end

   // R9 register holds without a load
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(rd_word));
   // R8 raw load keeps all bits
   p_raw_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !gen_en) |=> (rd_word == $past(rd_data)));
endmodule

// File: rtl/bytepar_port.sv
module bytepar_port
   import bytepar_pkg::*;
#(
   parameter int BYTES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    odd_sel,
   input  logic                    cs_n,
   input  logic                    en,
   input  logic                    wr_rd,
   input  logic                    mbox_sel,
   input  logic                    gen_en,
   input  logic [BYTES*LANE_W-1:0] bus_in,
   input  logic [BYTES*LANE_W-1:0] mail_data,
   output logic [BYTES*LANE_W-1:0] mail_out,
   input  logic                    rd_load,
   input  logic [BYTES*LANE_W-1:0] rd_data,
   output logic [BYTES*LANE_W-1:0] rd_word,
   output logic                    err_n
);
   localparam int WORD_W = BYTES * LANE_W;

   if (LANE_W < 2) begin : g_bad_lane
      $error("LANE_W must leave room for data and parity");
   end
   if (BYTES < 1) begin : g_bad_bytes
      $error("BYTES must be at least one");
   end

   par_mode_e mode;
   logic      mbox_rd;
   logic      mbox_gen;

   always_comb begin
      mode     = odd_sel ? PAR_ODD : PAR_EVEN;
      mbox_rd  = !cs_n && en && !wr_rd && mbox_sel;
      mbox_gen = mbox_rd && gen_en;
   end

   bytepar_shared #(.BYTES(BYTES), .LANE_W(LANE_W)) u_shared (
      .bus_in    (bus_in),
      .mail_data (mail_data),
      .mbox_gen  (mbox_gen),
      .mode      (mode),
      .mail_out  (mail_out),
      .err_n     (err_n)
   );

   bytepar_outreg #(.BYTES(BYTES), .LANE_W(LANE_W)) u_outreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (rd_load),
      .gen_en  (gen_en),
      .mode    (mode),
      .rd_data (rd_data),
      .rd_word (rd_word)
   );

   // R5 each generated mail lane carries the selected parity
   for (genvar b = 0; b < BYTES; b++) begin : g_chk
      p_mail_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
         mbox_gen |-> ((^mail_out[b*LANE_W +: LANE_W]) == odd_sel));
      p_fifo_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_load && gen_en) |=> ((^rd_word[b*LANE_W +: LANE_W]) == $past(odd_sel)));
   end

   // R6 mail word passes through untouched without generation
   p_mail_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !mbox_gen |-> (mail_out == mail_data));

   logic unused_w;
   always_comb unused_w = ^WORD_W;
endmodule

// File: tb/bytepar_port_test.sv
module bytepar_port_test;
   localparam int W = 36;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         odd_sel = 1'b1;
   logic         cs_n = 1'b1, en = 1'b0, wr_rd = 1'b1, mbox_sel = 1'b0, gen_en = 1'b0;
   logic [W-1:0] bus_in = '0, mail_data = '0, rd_data = '0;
   logic         rd_load = 1'b0;
   logic [W-1:0] mail_out, rd_word;
   logic         err_n;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   bytepar_port uut (
      .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .cs_n(cs_n), .en(en),
      .wr_rd(wr_rd), .mbox_sel(mbox_sel), .gen_en(gen_en), .bus_in(bus_in),
      .mail_data(mail_data), .mail_out(mail_out), .rd_load(rd_load),
      .rd_data(rd_data), .rd_word(rd_word), .err_n(err_n)
   );

   function automatic logic exp_err_n(input logic [W-1:0] w, input logic odd);
      logic bad = 1'b0;
      for (int b = 0; b < 4; b++) begin
         int zeros = 0;
         for (int i = 0; i < 9; i++) if (!w[b*9+i]) zeros++;
         if (odd && (zeros % 2 == 1)) bad = 1'b1;
         if (!odd && (zeros % 2 == 0)) bad = 1'b1;
      end
      return !bad;
   endfunction

   function automatic logic [W-1:0] exp_gen(input logic [W-1:0] w, input logic odd);
      logic [W-1:0] r = w;
      for (int b = 0; b < 4; b++) begin
         int ones = 0;
         for (int i = 0; i < 8; i++) if (w[b*9+i]) ones++;
         r[b*9+8] = odd ? (ones % 2 == 0) : (ones % 2 == 1);
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic idle_ctrl();
      cs_n = 1'b1; en = 1'b0; wr_rd = 1'b1; mbox_sel = 1'b0; gen_en = 1'b0; rd_load = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R9 reset value", rd_word, '0);
      rst_n = 1'b1;
   endtask

   task automatic t_odd_check();
      logic [W-1:0] pats [4] = '{36'h0, 36'h1_0000_0001, 36'h8_0201_0080, 36'hF_FFFF_FFFF};
      @(negedge clk); idle_ctrl(); odd_sel = 1'b1;
      foreach (pats[k]) begin
         bus_in = pats[k]; #1;
         check("R2 odd check", {35'b0, err_n}, {35'b0, exp_err_n(pats[k], 1'b1)});
      end
   endtask

   task automatic t_even_check();
      logic [W-1:0] pats [3] = '{36'h0, 36'h0_0000_0100, 36'h5_A5A5_A5A5};
      @(negedge clk); idle_ctrl(); odd_sel = 1'b0;
      foreach (pats[k]) begin
         bus_in = pats[k]; #1;
         check("R3 even check", {35'b0, err_n}, {35'b0, exp_err_n(pats[k], 1'b0)});
      end
   endtask

   task automatic t_lane_bounds();
      @(negedge clk); idle_ctrl(); odd_sel = 1'b1;
      bus_in = 36'h8_0201_0080 | 36'h0_0000_0001; #1;  // lane 0 broken
      check("R1 lane0 fail", {35'b0, err_n}, 36'h0);
      bus_in = 36'h8_0201_0080 ^ (36'h1 << 35); #1;   // lane 3 broken
      check("R1 lane3 fail", {35'b0, err_n}, 36'h0);
      bus_in = 36'h8_0201_0080; #1;
      check("R10 err follows bus", {35'b0, err_n}, 36'h1);
   endtask

   task automatic t_mbox_gen();
      @(negedge clk);
      cs_n = 1'b0; en = 1'b1; wr_rd = 1'b0; mbox_sel = 1'b1; gen_en = 1'b1;
      odd_sel = 1'b1; mail_data = 36'h1_2345_6789; bus_in = 36'h0; #1;
      check("R4 flag held high", {35'b0, err_n}, 36'h1);
      check("R5 mail odd gen", mail_out, exp_gen(36'h1_2345_6789, 1'b1));
      odd_sel = 1'b0; mail_data = 36'hF_0F0F_0F0F; #1;
      check("R5 mail even gen", mail_out, exp_gen(36'hF_0F0F_0F0F, 1'b0));
      check("R4 flag held high even", {35'b0, err_n}, 36'h1);
   endtask

   task automatic t_mbox_nogen();
      @(negedge clk);
      cs_n = 1'b0; en = 1'b1; wr_rd = 1'b0; mbox_sel = 1'b1; gen_en = 1'b0;
      odd_sel = 1'b1; mail_data = 36'h1_2345_6789; bus_in = 36'h0; #1;
      check("R6 mail raw", mail_out, 36'h1_2345_6789);
      check("R6 flag checks bus", {35'b0, err_n}, {35'b0, exp_err_n(36'h0, 1'b1)});
      gen_en = 1'b1; cs_n = 1'b1; #1;
      check("R6 deselected raw", mail_out, 36'h1_2345_6789);
   endtask

   task automatic t_fifo_gen();
      @(negedge clk); idle_ctrl();
      rd_data = 36'hA_BCDE_F012; gen_en = 1'b1; odd_sel = 1'b0; rd_load = 1'b1;
      @(negedge clk); rd_load = 1'b0; odd_sel = 1'b1;
      check("R7 fifo even gen", rd_word, exp_gen(36'hA_BCDE_F012, 1'b0));
      rd_data = 36'h3_3333_3333; rd_load = 1'b1;
      @(negedge clk); rd_load = 1'b0;
      check("R7 fifo odd gen", rd_word, exp_gen(36'h3_3333_3333, 1'b1));
   endtask

   task automatic t_fifo_raw();
      @(negedge clk); idle_ctrl();
      rd_data = 36'hF_FFFF_FFFE; gen_en = 1'b0; rd_load = 1'b1;
      @(negedge clk); rd_load = 1'b0;
      check("R8 fifo raw", rd_word, 36'hF_FFFF_FFFE);
      rd_data = 36'h0_1111_1111; gen_en = 1'b1;
      @(negedge clk);
      check("R9 fifo hold", rd_word, 36'hF_FFFF_FFFE);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         errors++;
         $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_odd_check();
      t_even_check();
      t_lane_bounds();
      t_mbox_gen();
      t_mbox_nogen();
      t_fifo_gen();
      t_fifo_raw();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule